// File: doc/BRIEF.md
# Cycle-Delayed Peripheral Bus Sequencer

This block runs single bus cycles on a small synchronous peripheral bus that is paced by an external phase clock `phi`. The bus has a 5-bit address, 8-bit data and three control lines: a read/write line and two active-low chip selects. The block takes one request at a time over a valid/ready handshake and drives the control lines, the shared address/data pins and their output enables. For a read, it returns the sampled byte on a one-cycle response strobe.

A timed write first waits a requested number of whole `phi` periods and then runs its bus cycle. This lets an upstream player place register writes at exact points on the peripheral's own timeline. Plain writes and reads start their cycle at the next `phi` low phase. Two special operations are also provided. A pause puts a fixed control pattern on the lines without touching the data pins. A bus clear turns every pin into an output driving zero and returns at once.

Within a cycle, the control pattern is applied a fixed settle time after `phi` is seen low. The address/data pins follow one clock later. Read data is sampled a second settle time after `phi` is seen high, and the control lines return to idle at that same edge. `phi` is taken to be synchronous to `clk`.

Top module: `cyc_bus_seq`

## Requirements
- R1: After reset, `ctrl` is 3'b111, `bus_out` and `bus_oe` are zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_op` codes are 0 write, 1 read, 2 timed write, 3 pause and 4 clear. `ctrl` is {rw, cs1_n, cs2_n}. Its patterns are 3'b001 for write and timed write, 3'b101 for read, 3'b110 for pause and 3'b111 when idle.
- R3: For write, read and pause, the pattern appears on `ctrl` exactly T_LOW clocks after the first clock edge that sees `phi` low after acceptance.
- R4: A timed write with count N lets exactly N+1 `phi` high-to-low transitions pass after acceptance. Its pattern appears T_LOW clocks after the last of them.
- R5: One clock after the pattern appears, the pins are driven as follows. For a write, `bus_out` = {3'b000, addr[4:0], data[7:0]} (address in bits 12:8, data in bits 7:0) and `bus_oe` = 16'h1FFF. For a read, `bus_out` = {3'b000, addr, 8'h00} and `bus_oe` = 16'h1F00.
- R6: After the pattern, at T_HIGH clocks past the first edge that sees `phi` high, `ctrl` returns to 3'b111. For a read, `rsp_valid` pulses for that one clock and `rsp_data` holds `bus_in` as sampled there. Writes and pauses give no response.
- R7: A pause leaves `bus_out` and `bus_oe` unchanged.
- R8: A clear sets `bus_out` to 0 and `bus_oe` to 16'hFFFF on the clock after acceptance. `ctrl` stays 3'b111 and `req_ready` stays 1.
- R9: `req_ready` is low while an access is in progress. It returns high on the first edge that sees `phi` low after `ctrl` returns to idle. `ctrl` is 3'b111 whenever `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| phi | input | 1 | Peripheral phase clock, synchronous to clk |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_op | input | 3 | Operation code (R2) |
| req_addr | input | 5 | Peripheral register address |
| req_data | input | 8 | Write data |
| req_cycles | input | 16 | Period count for timed writes |
| bus_in | input | 8 | Data pins as seen by the block |
| bus_out | output | 16 | Address/data pin values |
| bus_oe | output | 16 | Per-pin output enable |
| ctrl | output | 3 | {rw, cs1_n, cs2_n} |
| rsp_valid | output | 1 | Read byte strobe |
| rsp_data | output | 8 | Read byte |

## Verification
Random requests are timed from the start of a `phi` high phase. The bench measures each control change against the last `phi` fall or rise and counts the falls since acceptance. This separates the period-counting path of timed writes (counts 0 to 3, and a long count of 20) from the single-period wait of plain operations, and exposes an off-by-one in either settle time. Reads with random bus bytes tell sampled data apart from stale data. A clear followed by a pause shows whether a pause disturbs the pins. Comparing `bus_oe` on reads and writes shows whether data pins are wrongly enabled during a read.

// File: rtl/cyc_bus_seq.sv
module cyc_bus_seq #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int PW = 16,
  parameter int T_LOW = 26,
  parameter int T_HIGH = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [CW-1:0] req_cycles,
  input  logic [DW-1:0] bus_in,
  output logic [PW-1:0] bus_out,
  output logic [PW-1:0] bus_oe,
  output logic [2:0]    ctrl,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int TMAX = (T_LOW > T_HIGH) ? T_LOW : T_HIGH;
  localparam int TW = $clog2(TMAX + 1);
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TWR = 3'd2, OP_PAUSE = 3'd3, OP_CLR = 3'd4;
  localparam logic [2:0] P_IDLE = 3'b111, P_WR = 3'b001, P_RD = 3'b101, P_PAUSE = 3'b110;
  localparam logic [PW-1:0] M_D = {{(PW-DW){1'b0}}, {DW{1'b1}}};
  localparam logic [PW-1:0] M_A = {{(PW-AW-DW){1'b0}}, {AW{1'b1}}, {DW{1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_DH, S_DL, S_WL, S_SL, S_WH, S_SH, S_END} st_t;
  st_t st;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic          drv_pend;
  logic [2:0]    pat;

  assign req_ready = (st == S_IDLE);
  assign pat = (op_q == OP_RD) ? P_RD : (op_q == OP_PAUSE) ? P_PAUSE : P_WR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt <= '0;
      tmr <= '0;
      drv_pend <= 1'b0;
      ctrl <= P_IDLE;
      bus_out <= '0;
      bus_oe <= '0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      drv_pend <= 1'b0;
      if (drv_pend) begin
        if (op_q == OP_RD) begin
          bus_out <= {{(PW-AW-DW){1'b0}}, addr_q, {DW{1'b0}}};
          bus_oe <= M_A;
        end else begin
          bus_out <= {{(PW-AW-DW){1'b0}}, addr_q, data_q};
          bus_oe <= M_A | M_D;
        end
      end
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          if (req_op == OP_CLR) begin
            bus_out <= '0;
            bus_oe <= '1;
          end else if (req_op == OP_TWR) begin
            cnt <= req_cycles;
            st <= S_DH;
          end else if (req_op == OP_WR || req_op == OP_RD || req_op == OP_PAUSE) begin
            st <= S_WL;
          end
        end
        S_DH: if (phi) st <= S_DL;
        S_DL: if (!phi) begin
          if (cnt == '0) begin
            tmr <= TW'(T_LOW - 1);
            st <= S_SL;
          end else begin
            cnt <= cnt - 1'b1;
            st <= S_DH;
          end
        end
        S_WL: if (!phi) begin
          tmr <= TW'(T_LOW - 1);
          st <= S_SL;
        end
        S_SL: if (tmr == '0) begin
          ctrl <= pat;
          drv_pend <= (op_q != OP_PAUSE);
          st <= S_WH;
        end else tmr <= tmr - 1'b1;
        S_WH: if (phi) begin
          tmr <= TW'(T_HIGH - 1);
          st <= S_SH;
        end
        S_SH: if (tmr == '0) begin
          if (op_q == OP_RD) begin
            rsp_valid <= 1'b1;
            rsp_data <= bus_in;
          end
          ctrl <= P_IDLE;
          st <= S_END;
        end else tmr <= tmr - 1'b1;
        S_END: if (!phi) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ctrl == P_IDLE));
  assert_sample_phi_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(phi));
  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_pattern_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl) == P_IDLE && ctrl != P_IDLE) |-> !$past(phi));
  assert_clear_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == OP_CLR) |=> (bus_oe == '1 && bus_out == '0 && req_ready));
endmodule

// File: tb/cyc_bus_seq_tb.sv
`timescale 1ns/1ps
module cyc_bus_seq_tb;
  localparam int T_LOW = 26, T_HIGH = 24, HALF = 80;
  logic clk = 0, rst_n = 0, phi = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [2:0] req_op = 0;
  logic [4:0] req_addr = 0;
  logic [7:0] req_data = 0;
  logic [15:0] req_cycles = 0;
  logic [7:0] bus_in = 0;
  logic [15:0] bus_out, bus_oe;
  logic [2:0] ctrl;
  logic rsp_valid;
  logic [7:0] rsp_data;

  cyc_bus_seq u_dut (.clk(clk), .rst_n(rst_n), .phi(phi), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_cycles(req_cycles), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .ctrl(ctrl), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int falls = 0, since_fall = 0, since_rise = 0, ph = 0, rsp_cnt = 0;
  bit prev_seen = 0, acc_next = 0, act_pend = 0, prev_ready = 1;
  logic [2:0] prev_ctrl = 3'b111;
  int exp_kind = 0, exp_falls = 1;
  logic [2:0] exp_pat = 0;
  logic [15:0] exp_out = 0, exp_oe = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pat_of(input int k);
    case (k)
      1: return 3'b101;
      3: return 3'b110;
      default: return 3'b001;
    endcase
  endfunction

  always @(negedge clk) begin
    bit seen;
    seen = phi;
    if (prev_seen && !seen) begin since_fall = 0; falls++; end else since_fall++;
    if (!prev_seen && seen) since_rise = 0; else since_rise++;
    prev_seen = seen;
    if (rst_n) begin
      if (acc_next) begin
        acc_next = 0;
        falls = 0;
        if (exp_kind == 4) begin
          chk(bus_oe == 16'hFFFF && bus_out == 0, "R8 pins", bus_oe, 16'hFFFF);
          chk(ctrl == 3'b111 && req_ready, "R8 ctrl/ready", ctrl, 3'b111);
        end
      end
      if (act_pend) begin
        act_pend = 0;
        chk(bus_out == exp_out, (exp_kind == 3) ? "R7 out" : "R5 out", bus_out, exp_out);
        chk(bus_oe == exp_oe, (exp_kind == 3) ? "R7 oe" : "R5 oe", bus_oe, exp_oe);
      end
      if (prev_ctrl == 3'b111 && ctrl != 3'b111) begin
        chk(ctrl == exp_pat, "R2 pattern", ctrl, exp_pat);
        chk(falls == exp_falls, (exp_kind == 2) ? "R4 periods" : "R3 periods", falls, exp_falls);
        chk(since_fall == T_LOW, (exp_kind == 2) ? "R4 settle" : "R3 settle", since_fall, T_LOW);
        act_pend = 1;
      end
      if (prev_ctrl != 3'b111 && ctrl == 3'b111)
        chk(since_rise == T_HIGH, "R6 release", since_rise, T_HIGH);
      if (rsp_valid) begin
        rsp_cnt++;
        chk(since_rise == T_HIGH, "R6 sample time", since_rise, T_HIGH);
        chk(rsp_data == bus_in, "R6 data", rsp_data, bus_in);
      end
      if (!prev_ready && req_ready)
        chk(!seen && since_fall == 0, "R9 ready", since_fall, 0);
      if (req_valid && req_ready) acc_next = 1;
      prev_ctrl = ctrl;
      prev_ready = req_ready;
    end
    ph++;
    if (ph == HALF) begin ph = 0; phi = ~phi; end
  end

  task automatic do_op(input int op, input logic [4:0] a, input logic [7:0] d, input int cyc);
    wait (req_ready);
    @(posedge phi);
    @(posedge clk); #1;
    exp_kind = op;
    exp_pat = pat_of(op);
    exp_falls = (op == 2) ? cyc + 1 : 1;
    if (op == 1) begin exp_out = {3'b000, a, 8'h00}; exp_oe = 16'h1F00; end
    else if (op == 3) begin exp_out = bus_out; exp_oe = bus_oe; end
    else begin exp_out = {3'b000, a, d}; exp_oe = 16'h1FFF; end
    rsp_cnt = 0;
    bus_in = 8'($urandom);
    req_op = 3'(op); req_addr = a; req_data = d; req_cycles = 16'(cyc);
    req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    wait (req_ready);
    repeat (3) @(negedge clk);
    if (op != 4) chk(rsp_cnt == ((op == 1) ? 1 : 0), "R6 response count", rsp_cnt, (op == 1) ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(ctrl == 3'b111 && bus_out == 0 && bus_oe == 0 && req_ready && !rsp_valid, "R1 reset", ctrl, 3'b111);
    rst_n = 1;
    do_op(0, 5'h18, 8'h0F, 0);
    do_op(1, 5'h1B, 8'h00, 0);
    do_op(2, 5'h04, 8'h21, 0);
    do_op(2, 5'h05, 8'h11, 20);
    do_op(4, 5'h00, 8'h00, 0);
    do_op(3, 5'h00, 8'h00, 0);
    do_op(3, 5'h00, 8'h00, 0);
    for (int i = 0; i < 40; i++)
      do_op(int'($urandom % 5), 5'($urandom), 8'($urandom), int'($urandom % 4));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule